// File: doc/BRIEF.md
# Dual-Topology 16-bit Pseudo-Random Sequence Generator

This block steps a 16-bit maximal-length shift register once per enabled clock cycle. It produces a pseudo-random sequence of 65535 distinct states. A static parameter selects the register structure:

- **External feedback:** a single parity bit is formed from several state bits and enters at the top of the register.
- **Distributed feedback:** the bit leaving the bottom of the register toggles a mask of internal bits.

A second parameter swaps the XOR feedback for XNOR. This complements every state and moves the lock-up value from all zeros to all ones.

The feedback polynomial is x^16 + x^14 + x^13 + x^11 + 1, given as one parameter in the external-feedback form. The internal toggle mask is derived from it by bit-reversal, which is the mirrored tap set. With that mask, both structures emit the same serial stream, shifted in time.

A seed can be written at any time through a load strobe. A seed equal to the mode's lock-up value is refused: the state is kept and a one-cycle flag is raised.

Top module: `prng16_gen`

## Requirements
- R1: A synchronous reset sets the state to 0xACE1 with XOR feedback, or to 0x531E (its complement) with XNOR feedback. It clears the illegal-seed flag. Reset wins over load and enable.
- R2: In external-feedback form, each step shifts the state right by one. Bit 15 receives the XOR of old bits 0, 2, 3 and 5.
- R3: In distributed-feedback form, each step shifts the state right by one, with a 0 entering bit 15. If the old bit 0 was 1, the shifted value is XORed with 0xB400, which is the bit-reversal of the tap mask 0x002D.
- R4: With XNOR feedback, the state in every cycle is the bitwise complement of the XOR-feedback state of the same structure, when both start from complementary seeds. The lock-up value is 0xFFFF in place of 0x0000.
- R5: From the reset seed, the state first returns to the seed after exactly 65535 steps. The state never equals the mode's lock-up value.
- R6: The serial output stream x of either structure satisfies x[t+16] = x[t] ^ x[t+2] ^ x[t+3] ^ x[t+5]. The two structures therefore emit the same sequence, offset in time.
- R7: The serial output always equals state bit 0.
- R8: With enable low and no load, the state holds.
- R9: A load with a legal seed places that seed in the state at the next clock edge. The load takes priority over a step requested in the same cycle.
- R10: A load whose seed equals the lock-up value leaves the state unchanged, even with enable high. The illegal-seed flag goes high for exactly the following cycle and is low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Advance the sequence by one step |
| load | input | 1 | Write seed_in into the state |
| seed_in | input | 16 | Seed value presented with load |
| state | output | 16 | Registered state word |
| serial_out | output | 1 | Serial output bit (state bit 0) |
| bad_seed | output | 1 | One-cycle flag after a refused seed |

## Verification
Every result of this block lands in the edge after the stimulus, because state and flag are each one register deep:

- a step, load or reset applied before an edge is visible just after that edge;
- the refusal flag is visible only in the cycle that follows the refused load.

The bench changes inputs on falling edges and compares every output at the next falling edge, so each sample sits exactly one register stage after its cause. The full-period sweep follows this rule across all 65535 steps. It compares four instances (both structures, both feedback polarities) against arithmetic models on every cycle and records the first return to the seed. A further sample one cycle after each refused load confirms that the flag has dropped.

// File: rtl/prng16_pkg.sv
package prng16_pkg;

  typedef enum logic {
    TOPO_FIB = 1'b0,
    TOPO_GAL = 1'b1
  } topo_e;

endpackage

// File: rtl/prng16_step.sv
module prng16_step
  import prng16_pkg::*;
#(
  parameter int          W       = 16,
  parameter topo_e       TOPO    = TOPO_FIB,
  parameter bit          XNOR_FB = 1'b0,
  parameter logic [W-1:0] TAPS   = 16'h002D
) (
  input  logic [W-1:0] cur,
  output logic [W-1:0] nxt
);

  function automatic logic [W-1:0] reverse_bits(input logic [W-1:0] m);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[W-1-i] = m[i];
    return r;
  endfunction

  localparam logic [W-1:0] TOGGLE = reverse_bits(TAPS);

  logic [W-1:0] base;
  logic [W-1:0] adv;

  // XNOR polarity is handled as the complement of an XOR-form step
  generate
    if (XNOR_FB) begin : g_inv
      assign base = ~cur;
      assign nxt  = ~adv;
    end else begin : g_pass
      assign base = cur;
      assign nxt  = adv;
    end
  endgenerate

  generate
    if (TOPO == TOPO_FIB) begin : g_fib
      logic fb;
      assign fb  = ^(base & TAPS);
      assign adv = {fb, base[W-1:1]};
    end else begin : g_gal
      assign adv = {1'b0, base[W-1:1]} ^ (base[0] ? TOGGLE : '0);
    end
  endgenerate

endmodule

// File: rtl/prng16_seed_chk.sv
module prng16_seed_chk #(
  parameter int W       = 16,
  parameter bit XNOR_FB = 1'b0
) (
  input  logic [W-1:0] seed,
  output logic         legal
);

  localparam logic [W-1:0] LOCKUP = XNOR_FB ? {W{1'b1}} : {W{1'b0}};

  assign legal = (seed != LOCKUP);

endmodule

// File: rtl/prng16_gen.sv
module prng16_gen
  import prng16_pkg::*;
#(
  parameter int           W       = 16,
  parameter topo_e        TOPO    = TOPO_FIB,
  parameter bit           XNOR_FB = 1'b0,
  parameter logic [W-1:0] TAPS    = 16'h002D,
  parameter logic [W-1:0] SEED    = 16'hACE1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         load,
  input  logic [W-1:0] seed_in,
  output logic [W-1:0] state,
  output logic         serial_out,
  output logic         bad_seed
);

  localparam logic [W-1:0] RST_VAL = XNOR_FB ? ~SEED : SEED;
  localparam logic [W-1:0] LOCKUP  = XNOR_FB ? {W{1'b1}} : {W{1'b0}};

  logic [W-1:0] state_q;
  logic [W-1:0] step_val;
  logic         seed_ok;
  logic         bad_q;

  prng16_step #(
    .W(W), .TOPO(TOPO), .XNOR_FB(XNOR_FB), .TAPS(TAPS)
  ) u_step (
    .cur(state_q),
    .nxt(step_val)
  );

  prng16_seed_chk #(
    .W(W), .XNOR_FB(XNOR_FB)
  ) u_chk (
    .seed (seed_in),
    .legal(seed_ok)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= RST_VAL;
      bad_q   <= 1'b0;
    end else begin
      bad_q <= load && !seed_ok;
      if (load) begin
        if (seed_ok) state_q <= seed_in;
      end else if (en) begin
        state_q <= step_val;
      end
    end
  end

  assign state      = state_q;
  assign serial_out = state_q[0];
  assign bad_seed   = bad_q;

  // R1: reset value
  p_reset_value_r1: assert property (@(posedge clk)
    rst |=> (state == RST_VAL && !bad_seed));

  // R5: never in lock-up
  p_no_lockup_r5: assert property (@(posedge clk) disable iff (rst)
    state != LOCKUP);

  // R5: an enabled step always moves the state
  p_step_moves_r5: assert property (@(posedge clk) disable iff (rst)
    (en && !load) |=> state != $past(state));

  // R7: serial bit tracks state bit 0
  p_serial_bit_r7: assert property (@(posedge clk) disable iff (rst)
    serial_out == state[0]);

  // R8: idle holds
  p_idle_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!en && !load) |=> $stable(state));

  // R9: legal load lands next cycle
  p_load_lands_r9: assert property (@(posedge clk) disable iff (rst)
    (load && seed_ok) |=> state == $past(seed_in));

  // R10: refused load keeps state and raises flag
  p_refuse_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (load && !seed_ok) |=> ($stable(state) && bad_seed));

  // R10: flag only follows a load
  p_flag_cause_r10: assert property (@(posedge clk) disable iff (rst)
    bad_seed |-> $past(load));

endmodule

// File: tb/sim_prng16_gen.sv
`timescale 1ns/1ps
module sim_prng16_gen;
  import prng16_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0;
  logic        load = 1'b0;
  logic [15:0] seed_in = 16'h0000;

  logic [15:0] st0, st1, st2, st3;
  logic        so0, so1, so2, so3;
  logic        bs0, bs1, bs2, bs3;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  prng16_gen #(.TOPO(TOPO_FIB), .XNOR_FB(1'b0)) u0 (
    .clk(clk), .rst(rst), .en(en), .load(load), .seed_in(seed_in),
    .state(st0), .serial_out(so0), .bad_seed(bs0));
  prng16_gen #(.TOPO(TOPO_GAL), .XNOR_FB(1'b0)) u1 (
    .clk(clk), .rst(rst), .en(en), .load(load), .seed_in(seed_in),
    .state(st1), .serial_out(so1), .bad_seed(bs1));
  prng16_gen #(.TOPO(TOPO_FIB), .XNOR_FB(1'b1)) u2 (
    .clk(clk), .rst(rst), .en(en), .load(load), .seed_in(seed_in),
    .state(st2), .serial_out(so2), .bad_seed(bs2));
  prng16_gen #(.TOPO(TOPO_GAL), .XNOR_FB(1'b1)) u3 (
    .clk(clk), .rst(rst), .en(en), .load(load), .seed_in(seed_in),
    .state(st3), .serial_out(so3), .bad_seed(bs3));

  function automatic logic [15:0] fib_next(input logic [15:0] s);
    logic b;
    b = s[0] ^ s[2] ^ s[3] ^ s[5];
    return {b, s[15:1]};
  endfunction

  function automatic logic [15:0] gal_next(input logic [15:0] s);
    logic [15:0] r;
    r = s >> 1;
    if (s[0]) r = r ^ 16'hB400;
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  initial begin
    #900000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] mf, mg, lf, lg;
    logic [16:0] hf, hg;
    int ef, eg, ex2, ex3, eser, erf, erg, elk, retf, retg;
    ef = 0; eg = 0; ex2 = 0; ex3 = 0; eser = 0; erf = 0; erg = 0; elk = 0;
    retf = 0; retg = 0;

    repeat (3) tick();
    // R1 reset values
    chk("R1 u0 reset", {16'h0, st0}, {16'h0, 16'hACE1});
    chk("R1 u1 reset", {16'h0, st1}, {16'h0, 16'hACE1});
    chk("R1 u2 reset", {16'h0, st2}, {16'h0, 16'h531E});
    chk("R1 u3 reset", {16'h0, st3}, {16'h0, 16'h531E});
    chk("R1 flags clear", {28'h0, bs0, bs1, bs2, bs3}, 32'h0);
    rst = 1'b0;
    repeat (2) tick();
    // R8 idle hold
    chk("R8 idle hold u0", {16'h0, st0}, {16'h0, 16'hACE1});
    chk("R8 idle hold u3", {16'h0, st3}, {16'h0, 16'h531E});

    // full-period sweep: R2 R3 R4 R5 R6 R7
    mf = 16'hACE1; mg = 16'hACE1;
    hf = {16'h0, so0}; hg = {16'h0, so1};
    en = 1'b1;
    for (int k = 1; k <= 65535; k++) begin
      tick();
      mf = fib_next(mf);
      mg = gal_next(mg);
      if (st0 !== mf) ef++;
      if (st1 !== mg) eg++;
      if (st2 !== ~st0) ex2++;
      if (st3 !== ~st1) ex3++;
      if (so0 !== st0[0] || so1 !== st1[0] || so2 !== st2[0] || so3 !== st3[0]) eser++;
      if (st0 == 16'h0 || st1 == 16'h0 || st2 == 16'hFFFF || st3 == 16'hFFFF) elk++;
      if (retf == 0 && st0 == 16'hACE1) retf = k;
      if (retg == 0 && st1 == 16'hACE1) retg = k;
      hf = {hf[15:0], so0};
      hg = {hg[15:0], so1};
      if (k >= 16) begin
        if (hf[0] !== (hf[16] ^ hf[14] ^ hf[13] ^ hf[11])) erf++;
        if (hg[0] !== (hg[16] ^ hg[14] ^ hg[13] ^ hg[11])) erg++;
      end
    end
    en = 1'b0;
    chk("R2 fibonacci step mismatches", ef, 0);
    chk("R3 galois step mismatches", eg, 0);
    chk("R4 xnor fib complement mismatches", ex2, 0);
    chk("R4 xnor gal complement mismatches", ex3, 0);
    chk("R7 serial bit mismatches", eser, 0);
    chk("R5 lockup visits", elk, 0);
    chk("R5 fibonacci period", retf, 65535);
    chk("R5 galois period", retg, 65535);
    chk("R6 fibonacci stream recurrence", erf, 0);
    chk("R6 galois stream recurrence", erg, 0);

    // R9 legal load with enable high: load wins
    tick();
    load = 1'b1; seed_in = 16'h1234; en = 1'b1;
    tick();
    load = 1'b0; en = 1'b0;
    chk("R9 load priority u0", {16'h0, st0}, {16'h0, 16'h1234});
    chk("R9 load priority u1", {16'h0, st1}, {16'h0, 16'h1234});
    chk("R9 load priority u2", {16'h0, st2}, {16'h0, 16'h1234});
    chk("R10 no flag on legal load", {28'h0, bs0, bs1, bs2, bs3}, 32'h0);

    // R10 zero seed: refused by XOR instances, accepted by XNOR ones
    load = 1'b1; seed_in = 16'h0000; en = 1'b1;
    tick();
    load = 1'b0; en = 1'b0;
    chk("R10 refused zero keeps u0", {16'h0, st0}, {16'h0, 16'h1234});
    chk("R10 refused zero keeps u1", {16'h0, st1}, {16'h0, 16'h1234});
    chk("R10 flags after zero", {28'h0, bs0, bs1, bs2, bs3}, 32'hC);
    chk("R9 xnor accepts zero", {16'h0, st3}, {16'h0, 16'h0000});
    tick();
    chk("R10 flag one cycle", {28'h0, bs0, bs1, bs2, bs3}, 32'h0);
    chk("R8 hold after refuse", {16'h0, st0}, {16'h0, 16'h1234});

    // R10 all-ones seed: refused by XNOR instances
    load = 1'b1; seed_in = 16'hFFFF;
    tick();
    load = 1'b0;
    chk("R10 refused ones keeps u2", {16'h0, st2}, {16'h0, 16'h0000});
    chk("R10 flags after ones", {28'h0, bs0, bs1, bs2, bs3}, 32'h3);
    chk("R9 xor accepts ones", {16'h0, st0}, {16'h0, 16'hFFFF});
    tick();
    chk("R10 flag drops", {28'h0, bs0, bs1, bs2, bs3}, 32'h0);

    // single step from a fresh seed (R2, R3)
    load = 1'b1; seed_in = 16'hACE1;
    tick();
    load = 1'b0; en = 1'b1;
    tick();
    en = 1'b0;
    lf = fib_next(16'hACE1);
    lg = gal_next(16'hACE1);
    chk("R2 one step", {16'h0, st0}, {16'h0, lf});
    chk("R3 one step", {16'h0, st1}, {16'h0, lg});

    // R1 reset beats enable and load
    rst = 1'b1; en = 1'b1; load = 1'b1; seed_in = 16'h5555;
    tick();
    rst = 1'b0; en = 1'b0; load = 1'b0;
    chk("R1 reset priority u1", {16'h0, st1}, {16'h0, 16'hACE1});
    chk("R1 reset priority u2", {16'h0, st2}, {16'h0, 16'h531E});

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule